// File: doc/BRIEF.md
# Speculative Access Bit Conflict Detector

This block sits beside a direct-mapped cache tag array. It keeps one access bit for each cache set and uses it to record which blocks the local core has touched inside a speculative region. Every external coherence snoop is looked up in the tags. The access bit of the indexed set is read in that same lookup. When the snoop would break the atomicity of the speculative region, a sticky conflict flag is raised. The core can then abort, roll back its buffered state and take the lock for real.

Three pulses control the region. A begin pulse opens it, and a commit or abort pulse closes it. Any of the three clears every access bit and the conflict flag in a single cycle. The tag array is filled through a fill port. A fill that replaces a block the region has touched means that block can no longer be tracked, so it also raises the conflict. Data storage and the coherence state machine are outside this block. The only coherence state the block sees is one exclusive-or-shared bit per set, supplied by the surrounding logic.

Top module: `spec_abit_detector`

## Requirements
- R1: After reset, conflict_o is 0 and every tag entry is invalid, so no snoop hits.
- R2: A local access (acc_valid_i) that hits a valid tag while speculating sets the access bit of that set. The region is open from the cycle after a spec_begin_i pulse.
- R3: An invalidating snoop (snp_inv_i=1) that hits a set whose access bit is set drives conflict_o to 1 in the following cycle. conflict_o then holds until a begin, commit or abort pulse.
- R4: A read snoop (snp_inv_i=0) that hits a set whose access bit is set, while coh_excl_i for that set is 1 (exclusive), raises conflict_o in the following cycle.
- R5: A read snoop that hits a set whose access bit is set, while coh_excl_i for that set is 0 (shared), raises no conflict.
- R6: A snoop that misses in the tags (tag mismatch or invalid entry), or that hits a set whose access bit is clear, never raises a conflict.
- R7: While speculating, a fill that replaces a valid block whose access bit is set raises conflict_o in the following cycle. A fill into an invalid entry, or into a set whose access bit is clear, does not.
- R8: A commit or abort pulse clears conflict_o and all access bits by the next cycle, and ends the region.
- R9: Local accesses made outside a speculative region leave every access bit unchanged.
- R10: An invalidating snoop that hits a valid tag clears that entry's valid bit, so later accesses and snoops to it miss. A fill writes the tag and marks the entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spec_begin_i | input | 1 | Open a speculative region (pulse) |
| spec_commit_i | input | 1 | Close region, keep results (pulse) |
| spec_abort_i | input | 1 | Close region, discard results (pulse) |
| acc_valid_i | input | 1 | Local access strobe |
| acc_idx_i | input | IDX_W | Local access set index |
| acc_tag_i | input | TAG_W | Local access tag |
| snp_valid_i | input | 1 | External snoop strobe |
| snp_idx_i | input | IDX_W | Snoop set index |
| snp_tag_i | input | TAG_W | Snoop tag |
| snp_inv_i | input | 1 | Snoop kind: 1 invalidate, 0 read |
| coh_excl_i | input | 2**IDX_W | Per-set coherence state: 1 exclusive, 0 shared |
| fill_valid_i | input | 1 | Tag fill strobe |
| fill_idx_i | input | IDX_W | Fill set index |
| fill_tag_i | input | TAG_W | Fill tag |
| conflict_o | output | 1 | Sticky misspeculation flag |

## Verification
The hardest case to reach from the ports is the eviction conflict. It needs a valid block that has been touched inside an open region and is then replaced by a fill with a different tag, with no snoop involved. The bench fills a set, opens a region, accesses that set, then fills the same index with a new tag and checks the flag. It also fills an invalid set and an untouched valid set to show that neither of those raises a conflict. Region boundaries are exercised the same way. A snoop is repeated after an abort or a commit and a new begin, to show that the earlier access bits were really cleared.

// File: rtl/spec_abit_pkg.sv
package spec_abit_pkg;
  typedef enum logic {
    SNP_READ = 1'b0,
    SNP_INV  = 1'b1
  } snp_kind_e;
endpackage

// File: rtl/sabd_tag_array.sv
module sabd_tag_array #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 20,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_valid_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             inv_valid_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  input  logic [TAG_W-1:0] acc_tag_i,
  output logic             acc_hit_o,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  output logic             snp_hit_o,
  output logic             fill_victim_o
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_vld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                           vld_q[g] <= 1'b0;
      else if (fill_valid_i && fill_idx_i == IDX_W'(g))      vld_q[g] <= 1'b1;
      else if (inv_valid_i && inv_idx_i == IDX_W'(g))        vld_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_valid_i) tag_q[fill_idx_i] <= fill_tag_i;
  end

  assign acc_hit_o     = vld_q[acc_idx_i] && (tag_q[acc_idx_i] == acc_tag_i);
  assign snp_hit_o     = vld_q[snp_idx_i] && (tag_q[snp_idx_i] == snp_tag_i);
  assign fill_victim_o = vld_q[fill_idx_i];
endmodule

// File: rtl/sabd_abit_array.sv
module sabd_abit_array #(
  parameter int IDX_W = 6,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic             clr_valid_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic             set_valid_i,
  input  logic [IDX_W-1:0] set_idx_i,
  output logic [SETS-1:0]  bits_o
);
  logic [SETS-1:0] bits_q;

  // priority: flash clear, then fill clear, then access set
  for (genvar g = 0; g < SETS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        bits_q[g] <= 1'b0;
      else if (clr_all_i)                                 bits_q[g] <= 1'b0;
      else if (clr_valid_i && clr_idx_i == IDX_W'(g))     bits_q[g] <= 1'b0;
      else if (set_valid_i && set_idx_i == IDX_W'(g))     bits_q[g] <= 1'b1;
    end
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/sabd_conflict_eval.sv
module sabd_conflict_eval
  import spec_abit_pkg::*;
(
  input  logic      spec_i,
  input  logic      snp_valid_i,
  input  snp_kind_e snp_kind_i,
  input  logic      snp_hit_i,
  input  logic      snp_abit_i,
  input  logic      snp_excl_i,
  input  logic      fill_valid_i,
  input  logic      fill_victim_i,
  input  logic      fill_abit_i,
  output logic      snp_conf_o,
  output logic      evict_conf_o
);
  logic tracked_hit;

  always_comb begin
    tracked_hit  = spec_i && snp_valid_i && snp_hit_i && snp_abit_i;
    snp_conf_o   = tracked_hit && ((snp_kind_i == SNP_INV) || snp_excl_i);
    evict_conf_o = spec_i && fill_valid_i && fill_victim_i && fill_abit_i;
  end
endmodule

// File: rtl/spec_abit_detector.sv
module spec_abit_detector
  import spec_abit_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 20,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spec_begin_i,
  input  logic             spec_commit_i,
  input  logic             spec_abort_i,
  input  logic             acc_valid_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  input  logic [TAG_W-1:0] acc_tag_i,
  input  logic             snp_valid_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic             snp_inv_i,
  input  logic [SETS-1:0]  coh_excl_i,
  input  logic             fill_valid_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  output logic             conflict_o
);
  logic            spec_q, conflict_q;
  logic            acc_hit, snp_hit, fill_victim;
  logic            snp_conf, evict_conf;
  logic            region_edge;
  logic [SETS-1:0] abits;
  snp_kind_e       snp_kind;

  assign region_edge = spec_begin_i | spec_commit_i | spec_abort_i;
  assign snp_kind    = snp_kind_e'(snp_inv_i);

  sabd_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fill_valid_i  (fill_valid_i),
    .fill_idx_i    (fill_idx_i),
    .fill_tag_i    (fill_tag_i),
    .inv_valid_i   (snp_valid_i && snp_hit && (snp_kind == SNP_INV)),
    .inv_idx_i     (snp_idx_i),
    .acc_idx_i     (acc_idx_i),
    .acc_tag_i     (acc_tag_i),
    .acc_hit_o     (acc_hit),
    .snp_idx_i     (snp_idx_i),
    .snp_tag_i     (snp_tag_i),
    .snp_hit_o     (snp_hit),
    .fill_victim_o (fill_victim)
  );

  sabd_abit_array #(.IDX_W(IDX_W)) u_abits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_all_i   (region_edge),
    .clr_valid_i (fill_valid_i),
    .clr_idx_i   (fill_idx_i),
    .set_valid_i (spec_q && acc_valid_i && acc_hit),
    .set_idx_i   (acc_idx_i),
    .bits_o      (abits)
  );

  sabd_conflict_eval u_eval (
    .spec_i        (spec_q),
    .snp_valid_i   (snp_valid_i),
    .snp_kind_i    (snp_kind),
    .snp_hit_i     (snp_hit),
    .snp_abit_i    (abits[snp_idx_i]),
    .snp_excl_i    (coh_excl_i[snp_idx_i]),
    .fill_valid_i  (fill_valid_i),
    .fill_victim_i (fill_victim),
    .fill_abit_i   (abits[fill_idx_i]),
    .snp_conf_o    (snp_conf),
    .evict_conf_o  (evict_conf)
  );

  // commit/abort win over begin in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_q     <= 1'b0;
      conflict_q <= 1'b0;
    end else begin
      if (spec_commit_i || spec_abort_i) spec_q <= 1'b0;
      else if (spec_begin_i)             spec_q <= 1'b1;
      if (region_edge)                   conflict_q <= 1'b0;
      else if (snp_conf || evict_conf)   conflict_q <= 1'b1;
    end
  end

  assign conflict_o = conflict_q;
endmodule

module spec_abit_checker #(
  parameter int IDX_W = 6,
  localparam int SETS = 1 << IDX_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             spec_q,
  input logic             spec_begin_i,
  input logic             spec_commit_i,
  input logic             spec_abort_i,
  input logic             snp_valid_i,
  input logic             snp_inv_i,
  input logic             snp_hit,
  input logic [IDX_W-1:0] snp_idx_i,
  input logic [SETS-1:0]  abits,
  input logic             conflict_o
);
  logic edge_in;
  assign edge_in = spec_begin_i | spec_commit_i | spec_abort_i;

  // R8
  close_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_commit_i || spec_abort_i) |=> (!conflict_o && abits == '0 && !spec_q));

  // R3
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict_o && !edge_in) |=> conflict_o);

  // R3
  inv_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_q && !edge_in && snp_valid_i && snp_inv_i && snp_hit && abits[snp_idx_i])
    |=> conflict_o);

  // R9
  idle_bits_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spec_q |-> (abits == '0));

  // R6
  rise_in_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conflict_o) |-> $past(spec_q));
endmodule

bind spec_abit_detector spec_abit_checker #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .spec_q        (spec_q),
  .spec_begin_i  (spec_begin_i),
  .spec_commit_i (spec_commit_i),
  .spec_abort_i  (spec_abort_i),
  .snp_valid_i   (snp_valid_i),
  .snp_inv_i     (snp_inv_i),
  .snp_hit       (snp_hit),
  .snp_idx_i     (snp_idx_i),
  .abits         (abits),
  .conflict_o    (conflict_o)
);

// File: tb/tb_spec_abit_detector.sv
`timescale 1ns/1ps
module tb_spec_abit_detector;
  localparam int IDX_W = 6;
  localparam int TAG_W = 20;
  localparam int SETS  = 1 << IDX_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic spec_begin, spec_commit, spec_abort;
  logic acc_valid, snp_valid, snp_inv, fill_valid;
  logic [IDX_W-1:0] acc_idx, snp_idx, fill_idx;
  logic [TAG_W-1:0] acc_tag, snp_tag, fill_tag;
  logic [SETS-1:0]  excl;
  logic conflict;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  spec_abit_detector #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .spec_begin_i(spec_begin), .spec_commit_i(spec_commit), .spec_abort_i(spec_abort),
    .acc_valid_i(acc_valid), .acc_idx_i(acc_idx), .acc_tag_i(acc_tag),
    .snp_valid_i(snp_valid), .snp_idx_i(snp_idx), .snp_tag_i(snp_tag), .snp_inv_i(snp_inv),
    .coh_excl_i(excl),
    .fill_valid_i(fill_valid), .fill_idx_i(fill_idx), .fill_tag_i(fill_tag),
    .conflict_o(conflict)
  );

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s conflict_o actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle_all();
    {spec_begin, spec_commit, spec_abort, acc_valid, snp_valid, snp_inv, fill_valid} = '0;
  endtask

  // each op: drive after a falling edge, return at the next falling edge
  task automatic op_begin();  @(negedge clk); spec_begin = 1'b1;  @(negedge clk); idle_all(); endtask
  task automatic op_commit(); @(negedge clk); spec_commit = 1'b1; @(negedge clk); idle_all(); endtask
  task automatic op_abort();  @(negedge clk); spec_abort = 1'b1;  @(negedge clk); idle_all(); endtask
  task automatic op_fill(input int i, input int t);
    @(negedge clk); fill_valid = 1'b1; fill_idx = IDX_W'(i); fill_tag = TAG_W'(t);
    @(negedge clk); idle_all();
  endtask
  task automatic op_acc(input int i, input int t);
    @(negedge clk); acc_valid = 1'b1; acc_idx = IDX_W'(i); acc_tag = TAG_W'(t);
    @(negedge clk); idle_all();
  endtask
  task automatic op_snp(input int i, input int t, input logic inv);
    @(negedge clk); snp_valid = 1'b1; snp_idx = IDX_W'(i); snp_tag = TAG_W'(t); snp_inv = inv;
    @(negedge clk); idle_all();
  endtask

  task automatic t_reset();
    check(conflict, 1'b0, "R1 reset");
    op_begin();
    op_snp(0, 0, 1'b1);
    check(conflict, 1'b0, "R1 tags invalid after reset");
    op_commit();
  endtask

  task automatic t_inv_hit();
    op_fill(3, 'h1A);
    op_begin();
    op_acc(3, 'h1A);
    op_snp(3, 'h1A, 1'b1);
    check(conflict, 1'b1, "R2 R3 invalidate on tracked block");
    repeat (2) @(negedge clk);
    check(conflict, 1'b1, "R3 sticky");
    op_abort();
    check(conflict, 1'b0, "R8 abort clears flag");
    op_fill(3, 'h1A);
    op_begin();
    op_snp(3, 'h1A, 1'b1);
    check(conflict, 1'b0, "R8 abort cleared access bits");
    op_commit();
  endtask

  task automatic t_read_snoop();
    excl[5] = 1'b1;
    op_fill(5, 'h55);
    op_begin();
    op_acc(5, 'h55);
    op_snp(5, 'h55, 1'b0);
    check(conflict, 1'b1, "R4 read on exclusive tracked block");
    op_commit();
    check(conflict, 1'b0, "R8 commit clears flag");
    excl[5] = 1'b0;
    op_begin();
    op_acc(5, 'h55);
    op_snp(5, 'h55, 1'b0);
    check(conflict, 1'b0, "R5 read on shared tracked block");
    op_snp(5, 'h55, 1'b1);
    check(conflict, 1'b1, "R3 invalidate on shared tracked block");
    op_commit();
  endtask

  task automatic t_miss();
    op_fill(7, 'h77);
    op_fill(8, 'h88);
    op_begin();
    op_acc(8, 'h88);
    op_snp(8, 'h99, 1'b1);
    check(conflict, 1'b0, "R6 tag mismatch");
    op_snp(7, 'h77, 1'b1);
    check(conflict, 1'b0, "R6 untracked block");
    op_snp(20, 'h88, 1'b1);
    check(conflict, 1'b0, "R6 invalid entry");
    op_commit();
  endtask

  task automatic t_outside();
    op_fill(9, 'h9);
    op_acc(9, 'h9);
    op_begin();
    op_snp(9, 'h9, 1'b1);
    check(conflict, 1'b0, "R9 access outside region ignored");
    op_commit();
  endtask

  task automatic t_evict();
    op_fill(11, 'hA);
    op_fill(12, 'hC);
    op_begin();
    op_fill(30, 'h3);
    check(conflict, 1'b0, "R7 fill into invalid entry");
    op_fill(12, 'hD);
    check(conflict, 1'b0, "R7 fill over untracked block");
    op_acc(11, 'hA);
    op_fill(11, 'hB);
    check(conflict, 1'b1, "R7 eviction of tracked block");
    op_abort();
    check(conflict, 1'b0, "R8 abort after eviction");
  endtask

  task automatic t_inval_tag();
    op_fill(13, 'h13);
    op_snp(13, 'h13, 1'b1);
    op_begin();
    op_acc(13, 'h13);
    op_snp(13, 'h13, 1'b1);
    check(conflict, 1'b0, "R10 invalidated entry misses");
    op_commit();
    op_fill(13, 'h13);
    op_begin();
    op_acc(13, 'h13);
    op_snp(13, 'h13, 1'b1);
    check(conflict, 1'b1, "R10 refill marks entry valid");
    op_commit();
  endtask

  initial begin
    idle_all();
    acc_idx = '0; snp_idx = '0; fill_idx = '0;
    acc_tag = '0; snp_tag = '0; fill_tag = '0;
    excl = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_inv_hit();
    t_read_snoop();
    t_miss();
    t_outside();
    t_evict();
    t_inval_tag();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule